// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column-address stream of a four-bank synchronous DRAM during read and write bursts. A controller first programs a mode word with burst length, address ordering and read latency. It then issues a command with a bank, a row and a starting column. Beginning on the cycle after the command edge, the block presents one column address per clock, together with the bank, the row and the direction.

For read bursts, a data-valid strobe follows each address after the programmed CAS latency. A full-page burst walks the 512 columns of the open row with wrap-around and runs until a stop input ends it. A new command cuts short any burst that is still running.

The mode is held in a small register that accepts loads only while no burst is active. Each burst captures its length and ordering when its command is accepted. Each issued read beat carries its own latency into a delay line, so a later mode change cannot move strobes that are already scheduled.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset, `col_valid` and `rd_valid` are low, and the mode is burst length 1, sequential ordering, CAS latency 3.
- R2: When `mode_load` is high and no burst is active, the mode takes `mode_bl` (0=1 beat, 1=2, 2=4, 3=8, 7=full page, 4 to 6 = 1 beat), `mode_ilv` (1=interleaved) and `mode_cl3` (1=latency 3, 0=latency 2). A command in the same cycle still uses the previous mode.
- R3: A `mode_load` in a cycle where `col_valid` is high has no effect on the mode.
- R4: A command sampled at a clock edge makes `col_valid` high in the following cycle. That cycle shows beat 0, with `col_addr` equal to `cmd_col`, and echoes the command's bank, row and write flag.
- R5: With sequential ordering and a burst length of N in {2,4,8}, beat k addresses the start column with its low log2(N) bits replaced by (start + k) mod N.
- R6: With interleaved ordering and a burst length of N in {2,4,8}, beat k addresses the start column with its low log2(N) bits replaced by (start XOR k).
- R7: A fixed-length burst presents exactly N consecutive beats, after which `col_valid` goes low.
- R8: A full-page burst presents the start column plus k modulo 512 on beat k and continues without end. The interleave setting is ignored for this length.
- R9: `burst_stop` sampled at an edge with no command present ends the burst, so `col_valid` is low in the next cycle.
- R10: A command sampled during an active burst ends that burst. The next cycle shows beat 0 of the new command.
- R11: For every cycle with `col_valid` high and `col_write` low, `rd_valid` is high exactly L cycles later, where L is the latency in force during that cycle. Write beats never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_load | input | 1 | Strobe that loads the mode fields |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved ordering |
| mode_cl3 | input | 1 | 1 = read latency 3, 0 = read latency 2 |
| cmd_valid | input | 1 | Read or write command present |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 2 | Bank of the command |
| cmd_row | input | 13 | Row of the command |
| cmd_col | input | 9 | Starting column |
| burst_stop | input | 1 | Ends the active burst |
| col_valid | output | 1 | A beat address is presented |
| col_write | output | 1 | Direction of the current beat |
| col_bank | output | 2 | Bank of the current beat |
| col_row | output | 13 | Row of the current beat |
| col_addr | output | 9 | Column of the current beat |
| rd_valid | output | 1 | Read data valid strobe |

## Verification
The hardest situation to reach is a full-page burst that wraps past column 511 and then ends through the stop input rather than through a command. Random stimulus almost always truncates such a burst early. The bench therefore drives one long directed full-page write that starts at column 510, with interleave requested, and follows it with several hundred quiet cycles. Latency changes between read bursts and mode loads aimed into running bursts are mixed into a seeded random phase, and a bench-side model tracks the mode, the beat count and the scheduled strobes.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef struct packed {
    logic       full;  // full-page length
    logic [1:0] lg;    // log2 of fixed burst length
    logic       ilv;   // interleaved ordering requested
    logic       cl3;   // read latency 3 when set
  } seq_mode_t;

  localparam seq_mode_t MODE_RESET = '{full: 1'b0, lg: 2'd0, ilv: 1'b0, cl3: 1'b1};

  function automatic seq_mode_t decode_mode(input logic [2:0] bl, input logic ilv,
                                            input logic cl3);
    seq_mode_t m;
    m.full = 1'b0;
    m.lg   = 2'd0;
    m.ilv  = ilv;
    m.cl3  = cl3;
    case (bl)
      3'd1:    m.lg = 2'd1;
      3'd2:    m.lg = 2'd2;
      3'd3:    m.lg = 2'd3;
      3'd7:    m.full = 1'b1;
      default: m.lg = 2'd0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  logic      busy,
  input  logic [2:0] bl,
  input  logic      ilv,
  input  logic      cl3,
  output seq_mode_t mode
);

  seq_mode_t mode_q;
  seq_mode_t mode_d;
  logic      mode_en;

  always_comb begin
    mode_en = load & ~busy;
    mode_d  = decode_mode(bl, ilv, cl3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_mode_t         mode,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              stop,
  output logic              active,
  output logic              write,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);

  localparam logic [COL_W-1:0] ONE = COL_W'(1);

  logic              act_q, act_d;
  logic              wr_q, wr_d;
  logic              full_q, full_d;
  logic              ilv_q, ilv_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  start_q, start_d;
  logic [COL_W-1:0]  mask_q, mask_d;
  logic [COL_W-1:0]  cnt_q, cnt_d;
  logic              last_beat;
  logic              upd_en;

  always_comb begin
    last_beat = ~full_q & (cnt_q == mask_q);
    upd_en    = cmd_valid | act_q;
    act_d   = act_q;
    wr_d    = wr_q;
    full_d  = full_q;
    ilv_d   = ilv_q;
    bank_d  = bank_q;
    row_d   = row_q;
    start_d = start_q;
    mask_d  = mask_q;
    cnt_d   = cnt_q;
    if (cmd_valid) begin
      act_d   = 1'b1;
      wr_d    = cmd_write;
      full_d  = mode.full;
      ilv_d   = mode.ilv & ~mode.full;
      bank_d  = cmd_bank;
      row_d   = cmd_row;
      start_d = cmd_col;
      mask_d  = mode.full ? '1 : ((ONE << mode.lg) - ONE);
      cnt_d   = '0;
    end else if (act_q) begin
      if (stop || last_beat) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      start_q <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      full_q  <= full_d;
      ilv_q   <= ilv_d;
      bank_q  <= bank_d;
      row_q   <= row_d;
      start_q <= start_d;
      mask_q  <= mask_d;
      cnt_q   <= cnt_d;
    end
  end

  logic [COL_W-1:0] low_part;

  always_comb begin
    low_part = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
    col      = (start_q & ~mask_q) | (low_part & mask_q);
  end

  assign active = act_q;
  assign write  = wr_q;
  assign bank   = bank_q;
  assign row    = row_q;

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 3,
  localparam int NLAT  = CL_MAX - CL_MIN + 1,
  localparam int CLW   = $clog2(CL_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           beat_rd,
  input  logic [CLW-1:0] cas_lat,
  output logic           rd_valid
);

  logic [NLAT-1:0] tap;

  for (genvar g = 0; g < NLAT; g++) begin : g_lat
    localparam int L = CL_MIN + g;
    logic [L-1:0] sh_q, sh_d;
    logic         push;

    always_comb begin
      push = beat_rd & (cas_lat == CLW'(L));
      sh_d = {sh_q[L-2:0], push};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign tap[g] = sh_q[L-1];
  end

  assign rd_valid = |tap;

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int CL_MIN = 2,
  parameter int CL_MAX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [2:0]        mode_bl,
  input  logic              mode_ilv,
  input  logic              mode_cl3,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              burst_stop,
  output logic              col_valid,
  output logic              col_write,
  output logic [BANK_W-1:0] col_bank,
  output logic [ROW_W-1:0]  col_row,
  output logic [COL_W-1:0]  col_addr,
  output logic              rd_valid
);

  localparam int CLW = $clog2(CL_MAX + 1);

  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_s = rst_sync_q[1];

  seq_mode_t      mode_q;
  logic [CLW-1:0] cas_lat;

  sdram_mode_reg u_mode (
    .clk  (clk),
    .rst_n(rst_s),
    .load (mode_load),
    .busy (col_valid),
    .bl   (mode_bl),
    .ilv  (mode_ilv),
    .cl3  (mode_cl3),
    .mode (mode_q)
  );

  sdram_col_gen #(
    .COL_W (COL_W),
    .ROW_W (ROW_W),
    .BANK_W(BANK_W)
  ) u_col (
    .clk      (clk),
    .rst_n    (rst_s),
    .mode     (mode_q),
    .cmd_valid(cmd_valid),
    .cmd_write(cmd_write),
    .cmd_bank (cmd_bank),
    .cmd_row  (cmd_row),
    .cmd_col  (cmd_col),
    .stop     (burst_stop),
    .active   (col_valid),
    .write    (col_write),
    .bank     (col_bank),
    .row      (col_row),
    .col      (col_addr)
  );

  assign cas_lat = mode_q.cl3 ? CLW'(3) : CLW'(2);

  sdram_rd_pipe #(
    .CL_MIN(CL_MIN),
    .CL_MAX(CL_MAX)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_s),
    .beat_rd (col_valid & ~col_write),
    .cas_lat (cas_lat),
    .rd_valid(rd_valid)
  );

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_s,
  input seq_mode_t         mode_q,
  input logic              cmd_valid,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [COL_W-1:0]  cmd_col,
  input logic              burst_stop,
  input logic              col_valid,
  input logic              col_write,
  input logic [BANK_W-1:0] col_bank,
  input logic [ROW_W-1:0]  col_row,
  input logic [COL_W-1:0]  col_addr,
  input logic              rd_valid
);

  p_beat0_r4: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_valid |=> col_valid && col_addr == $past(cmd_col) &&
                  col_bank == $past(cmd_bank) && col_row == $past(cmd_row));

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_s)
    burst_stop && !cmd_valid |=> !col_valid);

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_s)
    col_valid |=> mode_q == $past(mode_q));

  p_rd_source_r11: assert property (@(posedge clk) disable iff (!rst_s)
    rd_valid |-> ($past(col_valid && !col_write, 2) || $past(col_valid && !col_write, 3)));

  p_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_s)
    col_valid && !cmd_valid |=> !col_valid ||
      (col_bank == $past(col_bank) && col_row == $past(col_row) && col_write == $past(col_write)));

endmodule

bind sdram_burst_seq sdram_seq_chk #(
  .COL_W (COL_W),
  .ROW_W (ROW_W),
  .BANK_W(BANK_W)
) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .mode_q    (mode_q),
  .cmd_valid (cmd_valid),
  .cmd_bank  (cmd_bank),
  .cmd_row   (cmd_row),
  .cmd_col   (cmd_col),
  .burst_stop(burst_stop),
  .col_valid (col_valid),
  .col_write (col_write),
  .col_bank  (col_bank),
  .col_row   (col_row),
  .col_addr  (col_addr),
  .rd_valid  (rd_valid)
);

// File: tb/sim_sdram_burst_seq.sv
module sim_sdram_burst_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_load, mode_ilv, mode_cl3;
  logic [2:0]  mode_bl;
  logic        cmd_valid, cmd_write, burst_stop;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_row;
  logic [8:0]  cmd_col;
  logic        col_valid, col_write, rd_valid;
  logic [1:0]  col_bank;
  logic [12:0] col_row;
  logic [8:0]  col_addr;

  always #5 clk = ~clk;

  sdram_burst_seq u0 (.*);

  int n_cmp = 0, n_bad = 0;
  int n_beats = 0, n_rd = 0;

  // bench-side expectation state
  int  m_len;  bit m_ilv; bit m_cl3;
  bit  e_act;  bit e_wr;  int e_bank; int e_row; int e_start; int e_len; bit e_ilv; int e_cnt;
  bit  sched[4];
  bit  e_rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dec_len(input bit [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      3'd7: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_addr(input int start, input int cnt, input int len, input bit ilv);
    int base, off;
    if (len == 0) return (start + cnt) % 512;
    base = start - (start % len);
    off  = start % len;
    if (ilv) return base + (off ^ cnt);
    return base + ((off + cnt) % len);
  endfunction

  task automatic model_reset();
    m_len = 1; m_ilv = 0; m_cl3 = 1;
    e_act = 0; e_wr = 0; e_bank = 0; e_row = 0; e_start = 0; e_len = 1; e_ilv = 0; e_cnt = 0;
    for (int i = 0; i < 4; i++) sched[i] = 0;
    e_rd = 0;
  endtask

  task automatic model_step();
    if (e_act && !e_wr) sched[m_cl3 ? 2 : 1] = 1;
    e_rd = sched[0];
    for (int i = 0; i < 3; i++) sched[i] = sched[i+1];
    sched[3] = 0;
    if (cmd_valid) begin
      e_act = 1; e_wr = cmd_write; e_bank = cmd_bank; e_row = cmd_row; e_start = cmd_col;
      e_len = m_len; e_ilv = m_ilv && (m_len != 0); e_cnt = 0;
    end else if (e_act) begin
      if (burst_stop || (e_len != 0 && e_cnt == e_len - 1)) e_act = 0;
      else e_cnt = (e_cnt + 1) % 512;
    end
    if (mode_load && !col_valid) begin
      m_len = dec_len(mode_bl); m_ilv = mode_ilv; m_cl3 = mode_cl3;
    end
  endtask

  task automatic compare();
    int ea;
    string tag;
    chk(col_valid === e_act, "R7", col_valid, e_act);
    if (e_act && col_valid) begin
      n_beats++;
      ea = exp_addr(e_start, e_cnt, e_len, e_ilv);
      if (e_cnt == 0) tag = "R4";
      else if (e_len == 0) tag = "R8";
      else if (e_ilv) tag = "R6";
      else tag = "R5";
      chk(col_addr == ea, tag, col_addr, ea);
      chk(col_bank == e_bank && col_row == e_row && col_write == e_wr, "R4",
          {col_write, col_bank, col_row}, {e_wr, 2'(e_bank), 13'(e_row)});
    end
    if (rd_valid) n_rd++;
    chk(rd_valid === e_rd, "R11", rd_valid, e_rd);
  endtask

  task automatic cyc(input bit ml, input bit [2:0] bl, input bit ilv, input bit cl3,
                     input bit cv, input bit cw, input bit [1:0] cb, input bit [12:0] cr,
                     input bit [8:0] cc, input bit st);
    mode_load = ml; mode_bl = bl; mode_ilv = ilv; mode_cl3 = cl3;
    cmd_valid = cv; cmd_write = cw; cmd_bank = cb; cmd_row = cr; cmd_col = cc;
    burst_stop = st;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load(input bit [2:0] bl, input bit ilv, input bit cl3);
    cyc(1, bl, ilv, cl3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cmd(input bit w, input bit [1:0] b, input bit [12:0] r, input bit [8:0] c);
    cyc(0, 0, 0, 0, 1, w, b, r, c, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [2:0] codes[6];
    codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd5};
    rst_n = 0;
    mode_load = 0; mode_bl = 0; mode_ilv = 0; mode_cl3 = 0;
    cmd_valid = 0; cmd_write = 0; cmd_bank = 0; cmd_row = 0; cmd_col = 0; burst_stop = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state, then default mode gives one beat with latency 3
    chk(col_valid === 1'b0, "R1", col_valid, 0);
    chk(rd_valid === 1'b0, "R1", rd_valid, 0);
    n_beats = 0; n_rd = 0;
    cmd(0, 2, 100, 7);
    idle(6);
    chk(n_beats == 1, "R1", n_beats, 1);
    chk(n_rd == 1, "R1", n_rd, 1);

    // R2 / R6: interleaved length 8, latency 2
    load(3'd3, 1, 0);
    n_beats = 0; n_rd = 0;
    cmd(0, 1, 55, 13);
    idle(12);
    chk(n_beats == 8, "R2", n_beats, 8);
    chk(n_rd == 8, "R2", n_rd, 8);

    // R2: reserved code acts as one beat
    load(3'd5, 0, 1);
    n_beats = 0;
    cmd(1, 3, 9, 300);
    idle(4);
    chk(n_beats == 1, "R2", n_beats, 1);

    // R3: load during an active burst is ignored
    load(3'd1, 0, 1);
    cmd(0, 0, 1, 5);
    load(3'd3, 1, 0);
    idle(4);
    n_beats = 0;
    cmd(0, 0, 1, 5);
    idle(8);
    chk(n_beats == 2, "R3", n_beats, 2);

    // R8 / R9: full page wrapping past 511, interleave ignored, ended by stop
    load(3'd7, 1, 1);
    n_beats = 0;
    cmd(1, 2, 4000, 510);
    idle(599);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk(n_beats == 600, "R8", n_beats, 600);
    chk(col_valid === 1'b0, "R9", col_valid, 0);
    idle(4);

    // R10: new command truncates an active burst
    load(3'd3, 0, 1);
    cmd(0, 0, 77, 0);
    idle(2);
    cmd(1, 1, 78, 20);
    chk(col_valid === 1'b1 && col_addr == 20, "R10", col_addr, 20);
    chk(col_write === 1'b1, "R10", col_write, 1);
    idle(12);

    // seeded random phase
    void'($urandom(32'h5d7a_1c03));
    for (int i = 0; i < 4000; i++) begin
      bit ml, cv, st;
      ml = ($urandom % 100) < 12;
      cv = ($urandom % 100) < 9;
      st = ($urandom % 100) < ((e_len == 0) ? 6 : 3);
      cyc(ml, codes[$urandom % 6], 1'($urandom), 1'($urandom), cv, 1'($urandom),
          2'($urandom), 13'($urandom), 9'($urandom), st);
    end
    idle(6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule